// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synchronous single-port memory with a shared data path and a fixed two-clock pipeline. A command is issued by pulling the load strobe low. The command can be a read burst, a write burst or a deselect. Each command then runs four beats on its own. Read data leaves the block and write data enters it in the same bus cycle slot: two enabled clocks after each beat's address. Because of this, read and write bursts can follow one another with no idle cycle between them.

The two low address bits step through a four-beat sequence. A static strap selects linear order (wrapping add) or interleaved order (XOR). Four active-low byte enables mask 9-bit lanes on writes. A clock enable freezes the whole block when it is high. The tri-state bus is split into `wdata`, `rdata` and `drive_en`, and an output enable gates `drive_en` without a clock. The array depth comes from the address-width parameter, so the array can stay small.

Top module: `nt_burst_sram`

## Requirements
- R1: At an enabled edge with `load_n` low, no burst in progress and the chip selected (`cs1_n`=0, `cs2`=1, `cs3_n`=0), a burst starts. It is a read when `rd_wr`=1 and a write when `rd_wr`=0.
- R2: Every burst has four beats, on the load edge and the next three enabled edges. Beat k (k = 0..3) keeps the upper address bits. Its two low bits are (start+k) mod 4 when `order_il`=0 and start XOR k when `order_il`=1.
- R3: If `load_n` is low at an enabled edge while a burst still has beats left (this includes loads on consecutive edges), the load is ignored. `proto_err` is then 1 after that edge. After an enabled edge with no such load, `proto_err` is 0.
- R4: For a read beat issued at enabled edge E, `rdata` holds the word at the beat's address after enabled edge E+2. Consecutive beats give data on consecutive enabled edges.
- R5: For a write beat issued at enabled edge E, `wdata` and `bw_n` are sampled at enabled edge E+2. Lane i is bits 9i+8..9i. It is written when `bw_n[i]`=0 and left unchanged when `bw_n[i]`=1.
- R6: `drive_en` is 1 only while the current data phase belongs to a read and `oe_n` is 0. It is 0 during write data phases whatever `oe_n` is, and it follows `oe_n` with no clock.
- R7: A load with any chip enable false starts a four-beat deselect that touches no memory. `drive_en` is 0 from the second enabled edge after the deselect load.
- R8: While `clk_en_n`=1, edges change no state: no write happens, loads are ignored, and `rdata`, `drive_en` and `proto_err` hold. A read phase stays driven.
- R9: After reset, `drive_en`=0, `proto_err`=0 and no burst is in progress.
- R10: A read burst and a write burst can be loaded exactly four enabled edges apart, in either order, with no idle cycle. Each one moves correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en_n | input | 1 | Active-low clock enable; high suspends the block |
| cs1_n | input | 1 | Active-low chip enable |
| cs2 | input | 1 | Active-high chip enable |
| cs3_n | input | 1 | Active-low chip enable |
| load_n | input | 1 | Active-low command load strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bw_n | input | 4 | Active-low byte-lane write enables |
| addr | input | ADDR_W | Burst start address |
| order_il | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| oe_n | input | 1 | Active-low output enable (combinational) |
| wdata | input | 36 | Write data in |
| rdata | output | 36 | Registered read data |
| drive_en | output | 1 | Data bus drive enable |
| proto_err | output | 1 | Load ignored because a burst was in progress |

## Verification
The bench fills the whole array and then reads it back with every start offset, in both burst orders. A design with the wrong order or no wrap would return data from the wrong words. Masked writes use varied `bw_n` patterns. Read and write bursts are packed back to back, and this would expose any extra turnaround cycle or a sampling of write data one beat off. Suspends are inserted mid-read and mid-write, loads are issued mid-burst and on consecutive edges, and deselects are issued with each chip enable false in turn. These catch a block that writes while frozen, lets a load restart a burst, or keeps driving after a deselect.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } op_e;

  // Low two address bits of a beat, given the start bits and the beat index.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] idx,
                                          input logic       il);
    logic [1:0] sum;
    sum = start + idx;
    return il ? (start ^ idx) : sum;
  endfunction

endpackage

// File: rtl/nt_sram_seq.sv
module nt_sram_seq
  import nt_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          load_n,
  input  logic          sel,
  input  logic          rd_wr,
  input  logic [AW-1:0] addr,
  input  logic          il,
  output op_e           beat_op,
  output logic [AW-1:0] beat_addr,
  output logic          proto_err
);
  localparam int UW = AW - 2;

  logic [1:0]    rem_q, idx_q, start_q, nidx;
  logic [UW-1:0] upper_q;
  op_e           op_q;
  logic          busy, accept, bad_load;

  assign busy     = (rem_q != 2'd0);
  assign accept   = ce & ~load_n & ~busy;
  assign bad_load = ce & ~load_n & busy;
  assign nidx     = idx_q + 2'd1;

  always_comb begin
    beat_op   = OP_IDLE;
    beat_addr = addr;
    if (!load_n && !busy) begin
      beat_op = sel ? (rd_wr ? OP_READ : OP_WRITE) : OP_DESEL;
    end else if (busy) begin
      beat_op   = op_q;
      beat_addr = {upper_q, beat_low(start_q, nidx, il)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q     <= 2'd0;
      idx_q     <= 2'd0;
      start_q   <= 2'd0;
      upper_q   <= '0;
      op_q      <= OP_IDLE;
      proto_err <= 1'b0;
    end else if (ce) begin
      proto_err <= bad_load;
      if (accept) begin
        rem_q   <= 2'd3;
        idx_q   <= 2'd0;
        start_q <= addr[1:0];
        upper_q <= addr[AW-1:2];
        op_q    <= sel ? (rd_wr ? OP_READ : OP_WRITE) : OP_DESEL;
      end else if (busy) begin
        rem_q <= rem_q - 2'd1;
        idx_q <= nidx;
      end
    end
  end

  // R3: a load during a burst raises the error flag
  a_r3_flag_bad_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load_n && busy) |=> proto_err);
  // R3: an ignored load must not restart the burst
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load_n && busy) |=> ($stable(start_q) && rem_q == $past(rem_q) - 2'd1));
  // R2: an accepted command yields three further beats
  a_r2_three_more: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rem_q == 2'd3 && idx_q == 2'd0));

endmodule

// File: rtl/nt_sram_pipe.sv
module nt_sram_pipe
  import nt_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  op_e           in_op,
  input  logic [AW-1:0] in_addr,
  output op_e           out_op,
  output logic [AW-1:0] out_addr
);
  op_e           op_q   [STAGES];
  logic [AW-1:0] addr_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        op_q[s]   <= OP_IDLE;
        addr_q[s] <= '0;
      end
    end else if (ce) begin
      op_q[0]   <= in_op;
      addr_q[0] <= in_addr;
      for (int s = 1; s < STAGES; s++) begin
        op_q[s]   <= op_q[s-1];
        addr_q[s] <= addr_q[s-1];
      end
    end
  end

  assign out_op   = op_q[STAGES-1];
  assign out_addr = addr_q[STAGES-1];

  // R8: the pipeline is frozen while the clock enable is off
  a_r8_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(out_op) && $stable(out_addr)));

endmodule

// File: rtl/nt_sram_core.sv
module nt_sram_core
  import nt_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  op_e                     ph_op,
  input  logic [AW-1:0]           ph_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        bw_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_phase
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wmask;
  logic          do_write, do_read;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wmask[i*LANE_W +: LANE_W] = {LANE_W{~bw_n[i]}};
  end

  assign do_write = ce & (ph_op == OP_WRITE);
  assign do_read  = ce & (ph_op == OP_READ);

  always_ff @(posedge clk) begin
    if (do_write) mem[ph_addr] <= (mem[ph_addr] & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_phase <= 1'b0;
    end else if (ce) begin
      rd_phase <= do_read;
      if (do_read) rdata <= mem[ph_addr];
    end
  end

  // R6: a write data phase never leaves a read phase behind
  a_r6_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ph_op == OP_WRITE) |=> !rd_phase);
  // R7: deselect beats end any read phase
  a_r7_desel_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ph_op == OP_DESEL) |=> !rd_phase);
  // R8: output register holds during suspend
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(rdata) && $stable(rd_phase)));

endmodule

// File: rtl/nt_burst_sram.sv
module nt_burst_sram
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              load_n,
  input  logic              rd_wr,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_il,
  input  logic              oe_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              drive_en,
  output logic              proto_err
);
  logic              ce, sel, rd_phase;
  op_e               beat_op, ph_op;
  logic [ADDR_W-1:0] beat_addr, ph_addr;

  assign ce  = ~clk_en_n;
  assign sel = ~cs1_n & cs2 & ~cs3_n;

  nt_sram_seq #(.AW(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .load_n(load_n), .sel(sel),
    .rd_wr(rd_wr), .addr(addr), .il(order_il),
    .beat_op(beat_op), .beat_addr(beat_addr), .proto_err(proto_err)
  );

  nt_sram_pipe #(.AW(ADDR_W), .STAGES(2)) pipe_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_op(beat_op), .in_addr(beat_addr),
    .out_op(ph_op), .out_addr(ph_addr)
  );

  nt_sram_core #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) core_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .ph_op(ph_op), .ph_addr(ph_addr),
    .wdata(wdata), .bw_n(bw_n), .rdata(rdata), .rd_phase(rd_phase)
  );

  assign drive_en = rd_phase & ~oe_n;

  // R9: nothing is driven or flagged out of reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (!drive_en && !proto_err));
  // R6: write data phase floats the bus
  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ph_op == OP_WRITE) |=> !drive_en);

endmodule

// File: tb/nt_burst_sram_tb_top.sv
`timescale 1ns/1ps
module nt_burst_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, clk_en_n, cs1_n, cs2, cs3_n, load_n, rd_wr, order_il, oe_n;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [35:0] wdata, rdata;
  logic        drive_en, proto_err;

  always #2.5 clk = ~clk;

  nt_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .load_n(load_n), .rd_wr(rd_wr), .bw_n(bw_n), .addr(addr),
    .order_il(order_il), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
    .drive_en(drive_en), .proto_err(proto_err)
  );

  int total = 0, bad = 0, tick = 0;
  string cur = "R9";
  bit g_cke_n = 0, g_oe_n = 0, g_il = 0;
  logic [3:0] g_bw = 4'h0;

  logic [35:0] ref_mem [64];
  int m_rem = 0, m_idx = 0, m_op = 0;
  logic [1:0] m_start = 0;
  logic [3:0] m_up = 0;
  int d1_op = 0, d2_op = 0;
  logic [5:0] d1_a = 0, d2_a = 0;
  logic [35:0] e_rd = 0;
  bit e_rdph = 0, e_err = 0;
  localparam bit [2:0] SEL = 3'b010;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] pat(input int n);
    logic [35:0] v;
    for (int i = 0; i < 4; i++) v[i*9 +: 9] = 9'((n * 37 + i * 101 + 5) & 511);
    return v;
  endfunction

  task automatic cyc(input bit ld, input bit [2:0] cs, input bit rw, input logic [5:0] a);
    logic [1:0] k2;
    @(negedge clk);
    load_n = !ld; {cs1_n, cs2, cs3_n} = cs; rd_wr = rw; addr = a;
    clk_en_n = g_cke_n; oe_n = g_oe_n; order_il = g_il; bw_n = g_bw;
    wdata = pat(tick); tick++;
    @(posedge clk); #1;
    if (!g_cke_n) begin
      if (d2_op == 2)
        for (int i = 0; i < 4; i++) if (!g_bw[i]) ref_mem[d2_a][i*9 +: 9] = wdata[i*9 +: 9];
      if (d2_op == 1) e_rd = ref_mem[d2_a];
      e_rdph = (d2_op == 1);
      d2_op = d1_op; d2_a = d1_a;
      e_err = ld && (m_rem > 0);
      if (ld && m_rem == 0) begin
        m_op = (cs == SEL) ? (rw ? 1 : 2) : 3;
        m_start = a[1:0]; m_up = a[5:2]; m_idx = 0; m_rem = 3;
        d1_op = m_op; d1_a = a;
      end else if (m_rem > 0) begin
        m_idx++; m_rem--;
        k2 = 2'(m_idx);
        d1_op = m_op;
        d1_a = {m_up, g_il ? (m_start ^ k2) : 2'((m_start + k2) % 4)};
      end else d1_op = 0;
    end
    chk({cur, " drive"}, {35'd0, drive_en}, {35'd0, e_rdph && !g_oe_n});
    chk("R3 proto_err", {35'd0, proto_err}, {35'd0, e_err});
    if (e_rdph) chk({cur, " rdata"}, rdata, e_rd);
  endtask

  task automatic burst(input bit rw, input logic [5:0] a);
    cyc(1, SEL, rw, a);
    repeat (3) cyc(0, SEL, 0, 6'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, SEL, 0, 6'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; clk_en_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; load_n = 1; rd_wr = 1;
    order_il = 0; oe_n = 0; bw_n = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 drive", {35'd0, drive_en}, 36'd0);
    chk("R9 err", {35'd0, proto_err}, 36'd0);
    @(negedge clk); rst_n = 1;

    cur = "R1";  // fill the array with back-to-back write bursts
    for (int k = 0; k < 16; k++) burst(0, {4'(k), 2'b00});
    idle(2);

    cur = "R4";  // linear reads from every start offset
    for (int k = 0; k < 16; k++) burst(1, {4'(k), 2'(k)});
    idle(2);

    cur = "R2";  // interleaved order
    g_il = 1;
    for (int k = 0; k < 8; k++) burst(1, {4'(k + 3), 2'(k + 1)});
    idle(2);
    g_il = 0;

    cur = "R5";  // masked writes, then read back
    for (int k = 0; k < 8; k++) begin g_bw = 4'(k * 3 + 1); burst(0, {4'(k), 2'b01}); end
    g_bw = 4'h0;
    for (int k = 0; k < 8; k++) burst(1, {4'(k), 2'b00});
    idle(2);

    cur = "R10";  // alternating read/write with no idle
    for (int k = 0; k < 8; k++) burst(k[0], {4'(k + 6), 2'(k)});
    idle(2);

    cur = "R7";  // deselect with each enable false
    burst(1, 6'd20);
    cyc(1, 3'b110, 1, 6'd0); idle(3);
    burst(0, 6'd24);
    cyc(1, 3'b000, 0, 6'd24); idle(3);
    burst(1, 6'd24);
    cyc(1, 3'b011, 0, 6'd24); idle(3);
    burst(1, 6'd24);
    idle(2);

    cur = "R3";  // loads during a burst are ignored
    cyc(1, SEL, 1, 6'd8);
    cyc(1, SEL, 0, 6'd40);
    cyc(1, SEL, 0, 6'd44);
    cyc(1, SEL, 1, 6'd12);
    idle(1);
    burst(1, 6'd40);
    idle(2);

    cur = "R8";  // suspends mid-read and mid-write
    cyc(1, SEL, 1, 6'd33);
    cyc(0, SEL, 0, 6'd0);
    cyc(0, SEL, 0, 6'd0);
    g_cke_n = 1; cyc(1, SEL, 0, 6'd2); cyc(1, 3'b110, 0, 6'd3); g_cke_n = 0;
    cyc(0, SEL, 0, 6'd0);
    idle(2);
    cyc(1, SEL, 0, 6'd50);
    cyc(0, SEL, 0, 6'd0);
    cyc(0, SEL, 0, 6'd0);
    g_cke_n = 1; g_bw = 4'h0; cyc(0, SEL, 0, 6'd0); cyc(1, SEL, 1, 6'd0); g_cke_n = 0;
    cyc(0, SEL, 0, 6'd0);
    idle(2);
    burst(1, 6'd48); burst(1, 6'd52);
    idle(2);

    cur = "R6";  // output enable gating of reads
    g_oe_n = 1;
    burst(1, 6'd16);
    cyc(0, SEL, 0, 6'd0);
    g_oe_n = 0; cyc(0, SEL, 0, 6'd0);
    g_oe_n = 1; cyc(0, SEL, 0, 6'd0);
    g_oe_n = 0;
    burst(0, 6'd60); burst(1, 6'd60);
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule